// File: doc/BRIEF.md
# ADC Sequencing Control Block

This block lets a processor run conversions on a multi-channel successive-approximation converter over a byte-wide register bus. Software writes a channel number, an enable bit and a mode bit into a control register, then sets a start bit. The block hands the request to the converter and holds the channel and mode steady until the converter reports done. It then captures the 10-bit result into two read-only registers, sets an end-of-conversion flag and, when interrupts are enabled, raises a level interrupt request.

A separate pin-configuration register marks which inputs are analog. It is driven out to the pad logic. A channel with no analog marking still converts, but its pad presents no signal. The flag is cleared only by software, and the interrupt cannot fire again until that is done. The precision mode lowers digital noise around the conversion and relies on the interrupt to wake software. For that reason, a precision start is refused while the interrupt enable is 0.

Register map, by 3-bit address: 0 control, 1 pin configuration, 2 result high byte, 3 result low bits, 4 interrupt enable (bit 0). Control register fields: [2:0] channel, [3] start, [4] end-of-conversion flag, [5] enable, [6] precision mode, [7] reads 0.

Top module: `adc_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is 0, `ain_mask_o` is 0 and `conv_start_o` is 0.
- R2: A control write with bit 3 = 1 and bit 5 = 1 makes `conv_start_o` high for exactly one cycle. After that, control bit 3 reads 0. If the same write has bit 5 = 0, no conversion starts.
- R3: `conv_chan_o` carries control bits [2:0] and `conv_prec_o` carries control bit 6, both as they were when the start was accepted. Both stay stable until done.
- R4: A start written while a conversion is pending or running is ignored. The running conversion keeps its channel and its result.
- R5: A start with bit 6 = 1 while the interrupt-enable bit (address 4, bit 0) is 0 is ignored. No conversion begins.
- R6: On the cycle `conv_done_i` ends a running conversion, control bit 4 is set and both result registers load together. A control write with bit 4 = 1 leaves the flag unchanged. A control write with bit 4 = 0 clears it.
- R7: `irq_o` is high exactly while the flag is set and the interrupt enable is 1. It stays high until the flag is cleared.
- R8: Address 2 reads result bits [9:2]. Address 3 reads result bits [1:0] in bits [1:0], with its upper bits 0.
- R9: Address 1 is read/write and drives `ain_mask_o`. A conversion on a channel whose bit is 0 still completes, and with the pad stub it returns 0.
- R10: `conv_done_i` while no conversion is running changes neither the flag nor the result registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Bus write (1) / read (0) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| conv_start_o | output | 1 | One-cycle start to converter |
| conv_chan_o | output | 3 | Channel to convert |
| conv_prec_o | output | 1 | Precision-mode request |
| conv_done_i | input | 1 | Converter completion pulse |
| conv_result_i | input | 10 | Converter result, valid with done |
| ain_mask_o | output | 8 | Analog-input pin selection |
| irq_o | output | 1 | End-of-conversion interrupt request |

## Verification
The bench builds the block with its default 8 channels and 10-bit result, and uses a converter stub with a 5-cycle latency. This is small enough to sweep every channel in both modes under two complementary pin masks. That sweep covers each converted channel and each unconfigured, zero-returning channel in both standard and precision mode. The bench then issues refused starts (disabled, busy, precision without interrupt enable) and an idle done pulse. It also writes 1 to the flag and then 0, and it compares every result against an arithmetic model of the stub.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_CFG  = 3'd1,
    A_RHI  = 3'd2,
    A_RLO  = 3'd3,
    A_IEN  = 3'd4
  } addr_e;

  localparam int unsigned B_START = 3;
  localparam int unsigned B_EOC   = 4;
  localparam int unsigned B_EN    = 5;
  localparam int unsigned B_PREC  = 6;
endpackage

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq #(
  parameter int unsigned CH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pend_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic            prec_i,
  input  logic            done_i,
  output logic            start_o,
  output logic [CH_W-1:0] chan_o,
  output logic            prec_o,
  output logic            busy_o,
  output logic            cap_o
);
  logic            busy_q;
  logic [CH_W-1:0] chan_q;
  logic            prec_q;

  assign start_o = pend_i && !busy_q;
  assign cap_o   = done_i && busy_q;
  assign busy_o  = busy_q;
  // hold channel and mode while running; present live field at start
  assign chan_o  = busy_q ? chan_q : chan_i;
  assign prec_o  = busy_q ? prec_q : prec_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      chan_q <= '0;
      prec_q <= 1'b0;
    end else if (start_o) begin
      busy_q <= 1'b1;
      chan_q <= chan_i;
      prec_q <= prec_i;
    end else if (cap_o) begin
      busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned NCH   = 8,
  parameter int unsigned RES_W = 10,
  localparam int unsigned CH_W = $clog2(NCH),
  localparam int unsigned LO_W = RES_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              accept_i,
  input  logic              cap_i,
  input  logic [RES_W-1:0]  res_i,
  input  logic              busy_i,
  output logic [CH_W-1:0]   chan_o,
  output logic              prec_o,
  output logic              pend_o,
  output logic              eoc_o,
  output logic              ien_o,
  output logic [NCH-1:0]    mask_o
);
  logic              wr, wr_ctrl, start_req;
  logic [CH_W-1:0]   chan_q;
  logic              en_q, prec_q, start_q, eoc_q, ien_q;
  logic [NCH-1:0]    mask_q;
  logic [RES_W-1:0]  res_q;

  assign wr      = sel_i && we_i;
  assign wr_ctrl = wr && (addr_i == A_CTRL);
  assign start_req = wr_ctrl && wdata_i[B_START] && wdata_i[B_EN]
                   && !busy_i && !start_q
                   && !(wdata_i[B_PREC] && !ien_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q  <= '0;
      en_q    <= 1'b0;
      prec_q  <= 1'b0;
      start_q <= 1'b0;
      eoc_q   <= 1'b0;
      ien_q   <= 1'b0;
      mask_q  <= '0;
      res_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        chan_q <= wdata_i[CH_W-1:0];
        en_q   <= wdata_i[B_EN];
        prec_q <= wdata_i[B_PREC];
      end
      if (accept_i)       start_q <= 1'b0;
      else if (start_req) start_q <= 1'b1;
      // set has priority over a software clear in the same cycle
      if (cap_i)                              eoc_q <= 1'b1;
      else if (wr_ctrl && !wdata_i[B_EOC])    eoc_q <= 1'b0;
      if (wr && addr_i == A_CFG) mask_q <= wdata_i[NCH-1:0];
      if (wr && addr_i == A_IEN) ien_q  <= wdata_i[0];
      if (cap_i) res_q <= res_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && !we_i) begin
      unique case (addr_i)
        A_CTRL: begin
          rdata_o[CH_W-1:0] = chan_q;
          rdata_o[B_START]  = start_q;
          rdata_o[B_EOC]    = eoc_q;
          rdata_o[B_EN]     = en_q;
          rdata_o[B_PREC]   = prec_q;
        end
        A_CFG:   rdata_o[NCH-1:0]  = mask_q;
        A_RHI:   rdata_o           = res_q[RES_W-1:LO_W];
        A_RLO:   rdata_o[LO_W-1:0] = res_q[LO_W-1:0];
        A_IEN:   rdata_o[0]        = ien_q;
        default: rdata_o = '0;
      endcase
    end
  end

  assign chan_o = chan_q;
  assign prec_o = prec_q;
  assign pend_o = start_q;
  assign eoc_o  = eoc_q;
  assign ien_o  = ien_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/adc_ctrl.sv
module adc_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned NCH   = 8,
  parameter int unsigned RES_W = 10,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              conv_start_o,
  output logic [CH_W-1:0]   conv_chan_o,
  output logic              conv_prec_o,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_result_i,
  output logic [NCH-1:0]    ain_mask_o,
  output logic              irq_o
);
  logic            pend, busy, cap, eoc, ien, prec;
  logic [CH_W-1:0] chan;

  adc_ctrl_regs #(.NCH(NCH), .RES_W(RES_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .accept_i (conv_start_o),
    .cap_i    (cap),
    .res_i    (conv_result_i),
    .busy_i   (busy),
    .chan_o   (chan),
    .prec_o   (prec),
    .pend_o   (pend),
    .eoc_o    (eoc),
    .ien_o    (ien),
    .mask_o   (ain_mask_o)
  );

  adc_ctrl_seq #(.CH_W(CH_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (pend),
    .chan_i  (chan),
    .prec_i  (prec),
    .done_i  (conv_done_i),
    .start_o (conv_start_o),
    .chan_o  (conv_chan_o),
    .prec_o  (conv_prec_o),
    .busy_o  (busy),
    .cap_o   (cap)
  );

  assign irq_o = eoc && ien;
endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned CH_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              conv_start_o,
  input logic [CH_W-1:0]   conv_chan_o,
  input logic              conv_prec_o,
  input logic              conv_done_i,
  input logic              irq_o,
  input logic              busy,
  input logic              eoc,
  input logic              ien
);
  logic clr_wr;
  assign clr_wr = sel_i && we_i && (addr_i == A_CTRL) && !wdata_i[B_EOC];

  // R2
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
  // R4
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> !busy);
  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && $past(busy) |-> $stable(conv_chan_o) && $stable(conv_prec_o));
  // R5
  prec_ien_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o && conv_prec_o |-> ien);
  // R6
  eoc_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i && busy |=> eoc);
  // R6
  eoc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(eoc) |-> $past(clr_wr));
  // R10
  idle_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i && !busy && !eoc |=> !eoc);
  // R7
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> eoc && ien);
endmodule

bind adc_ctrl adc_ctrl_chk #(.CH_W(CH_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sel_i        (sel_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .conv_start_o (conv_start_o),
  .conv_chan_o  (conv_chan_o),
  .conv_prec_o  (conv_prec_o),
  .conv_done_i  (conv_done_i),
  .irq_o        (irq_o),
  .busy         (busy),
  .eoc          (eoc),
  .ien          (ien)
);

// File: tb/adc_ctrl_bench.sv
module adc_ctrl_bench;
  localparam int LAT = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       c_start, c_prec, irq;
  logic [2:0] c_chan;
  logic       c_done;
  logic [9:0] c_res;
  logic [7:0] ain;

  logic       s_done = 1'b0, inj = 1'b0;
  logic [9:0] s_res = '0;
  int         s_cnt = 0;
  int         s_chan = 0, s_prec = 0;
  int         n_start = 0;
  int         checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  assign c_done = s_done | inj;
  assign c_res  = inj ? 10'h3FF : s_res;

  adc_ctrl u_adc_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .conv_start_o(c_start),
    .conv_chan_o(c_chan), .conv_prec_o(c_prec), .conv_done_i(c_done),
    .conv_result_i(c_res), .ain_mask_o(ain), .irq_o(irq)
  );

  function automatic int model(int ch, int pr);
    return (ch * 113 + pr * 7 + 9) & 10'h3FF;
  endfunction

  // converter stub: unconfigured pad reads as zero
  always @(posedge clk) begin
    s_done <= 1'b0;
    if (c_start) begin
      n_start <= n_start + 1;
      s_cnt   <= LAT;
      s_chan  <= int'(c_chan);
      s_prec  <= int'(c_prec);
    end else if (s_cnt > 0) begin
      s_cnt <= s_cnt - 1;
      if (s_cnt == 1) begin
        s_done <= 1'b1;
        s_res  <= ain[s_chan] ? 10'(model(s_chan, s_prec)) : 10'd0;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = 3'(a); wdata = 8'(d);
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = 3'(a);
    #1 d = int'(rdata);
    sel = 1'b0;
  endtask

  task automatic wait_eoc(output int ctrl);
    ctrl = 0;
    for (int i = 0; i < 40; i++) begin
      rd(0, ctrl);
      if (ctrl[4]) break;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run(int mask, int ch, int pr, int ie);
    int v, c, hi, lo, exp, st0;
    st0 = n_start;
    wr(4, ie);
    wr(0, 8'h28 | ch | (pr << 6));
    wait_eoc(c);
    exp = mask[ch] ? model(ch, pr) : 0;
    check("R2 one start", n_start - st0, 1);
    check("R2 start bit self-clears", c & 8'h08, 0);
    check("R6 eoc set", (c >> 4) & 1, 1);
    check("R3 channel", s_chan, ch);
    check("R3 mode", s_prec, pr);
    check("R7 irq level", int'(irq), ie);
    rd(2, hi);
    rd(3, lo);
    check("R8 high byte", hi, exp >> 2);
    check("R8 low bits", lo, exp & 3);
    check("R9 result of pin mask", (hi << 2) + lo, exp);
    wr(0, 8'h30 | ch);
    rd(0, v);
    check("R6 write 1 keeps flag", (v >> 4) & 1, 1);
    check("R7 irq held", int'(irq), ie);
    wr(0, 8'h20 | ch);
    rd(0, v);
    check("R6 write 0 clears flag", (v >> 4) & 1, 0);
    check("R7 irq drops", int'(irq), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual expired expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, st0, hi0, lo0;
    int masks[2] = '{8'h0C, 8'hF3};
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(a, v);
      check("R1 reset register", v, 0);
    end
    check("R1 irq", int'(irq), 0);
    check("R1 mask", int'(ain), 0);
    check("R1 start", int'(c_start), 0);

    foreach (masks[m]) begin
      wr(1, masks[m]);
      rd(1, v);
      check("R9 cfg readback", v, masks[m]);
      check("R9 mask pins", int'(ain), masks[m]);
      for (int ch = 0; ch < 8; ch++)
        for (int pr = 0; pr < 2; pr++)
          run(masks[m], ch, pr, pr ? 1 : (ch & 1));
    end

    // R2 start with enable 0 ignored
    st0 = n_start;
    wr(0, 8'h08 | 2);
    idle(12);
    rd(0, v);
    check("R2 disabled start", n_start - st0, 0);
    check("R2 disabled no pending", v & 8'h18, 0);

    // R5 precision without interrupt enable
    wr(4, 0);
    wr(0, 8'h68 | 1);
    idle(12);
    rd(0, v);
    check("R5 refused precision", n_start - st0, 0);
    check("R5 no pending, no flag", v & 8'h18, 0);

    // R4 start while busy: second request ignored
    wr(1, 8'hFF);
    wr(0, 8'h28 | 1);
    wr(0, 8'h28 | 6);
    wait_eoc(v);
    idle(12);
    rd(0, v);
    check("R4 single start", n_start - st0, 1);
    check("R4 first channel kept", s_chan, 1);
    rd(2, hi0);
    rd(3, lo0);
    check("R4 first result kept", (hi0 << 2) + lo0, model(1, 0));
    wr(0, 8'h20);

    // R10 done while idle
    @(negedge clk); inj = 1'b1;
    @(negedge clk); inj = 1'b0;
    rd(0, v);
    check("R10 flag untouched", (v >> 4) & 1, 0);
    rd(2, v);
    check("R10 high untouched", v, hi0);
    rd(3, v);
    check("R10 low untouched", v, lo0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule